// File: doc/BRIEF.md
# Programmable Parallel I/O Port Controller

This block sits on a simple CPU bus and turns it into three byte-wide parallel ports. Ports A and B are whole bytes with one direction each. Port C is split into a high nibble and a low nibble, and each nibble has its own direction. A single control address takes two kinds of command. When bit 7 is 1, the command sets the port directions and stores the handshake mode bits. When bit 7 is 0, the command sets or clears one bit of port C. Only plain input/output behaviour is built. The stored mode bits are passed to the output pins for neighbouring logic to use.

The bus is synchronous to `clk` and has no back-pressure. A write takes effect at every rising edge where `cs_n` and `wr_n` are both low. A read is combinational while `cs_n` and `rd_n` are both low. Each pad is modelled as three separate vectors: an input, an output and an output enable.

Top module: `ppio_ctrl`

## Requirements
- R1: When `rst` is high, every output enable goes to 0, every output latch is cleared to 0, and the stored mode bits are cleared. The ports are therefore released as inputs.
- R2: A write with bit 7 = 1 to address 3 defines the directions. Bit 4 sets port A, bit 3 the high nibble of C, bit 1 port B and bit 0 the low nibble of C. A value of 1 makes that part an input, and its output enable bits are then 0. A value of 0 makes it an output, and its output enable bits are then 1.
- R3: A direction definition clears the output latches of ports A, B and C.
- R4: A write with bit 7 = 0 to address 3 changes exactly one bit of the port C latch. Bits 3..1 select the bit number, and bit 0 is 1 to set the bit or 0 to clear it. Bits 6..4 have no effect. A changed bit keeps its value until it is written again.
- R5: A bit set/clear command leaves the directions and mode bits unchanged.
- R6: A write to address 0 loads the port A latch, and a write to address 1 loads the port B latch. Each latch drives its port's output vector.
- R7: A write to address 2 changes only the port C latch nibbles that are configured as outputs.
- R8: A read of address 0, 1 or 2 returns the input pins for bits configured as input and the latch for bits configured as output. For port C this choice is made per nibble.
- R9: A read of address 3 returns 0 and changes no state.
- R10: The data bus is driven only while `cs_n` and `rd_n` are both low. At all other times `rdata` is 0 and `rdata_oe` is 0. A write strobe has no effect while `cs_n` is high.
- R11: A direction definition stores bits 6..5 as the group A mode and bit 2 as the group B mode. These values appear on `mode_a` and `mode_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select: 0 = A, 1 = B, 2 = C, 3 = control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not driven |
| rdata_oe | output | 1 | Data bus drive enable |
| pa_in | input | 8 | Port A pad input |
| pa_out | output | 8 | Port A latch |
| pa_oe | output | 8 | Port A output enable |
| pb_in | input | 8 | Port B pad input |
| pb_out | output | 8 | Port B latch |
| pb_oe | output | 8 | Port B output enable |
| pc_in | input | 8 | Port C pad input |
| pc_out | output | 8 | Port C latch |
| pc_oe | output | 8 | Port C output enable |
| mode_a | output | 2 | Stored group A mode |
| mode_b | output | 1 | Stored group B mode |

## Verification
The bench steps through a table of direction words. The table covers all-output, all-input and each single part as input, plus two words with nonzero mode bits. For each word the bench checks that the mode bits land on the right pins and that the enables belong to the right port. It then writes 0xFF to port C and reads C back while the pins are held at 0x3C. This shows whether nibble masking and the per-nibble read select follow the high and low directions separately. Directed tests cover the following:
- bit set/clear commands with junk in bits 6..4;
- reads of input pins;
- a read of the control address;
- writes with chip select high;
- a reset applied after the ports have been configured.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
  typedef struct packed {
    logic [1:0] mode_a;
    logic       in_a;
    logic       in_cu;
    logic       mode_b;
    logic       in_b;
    logic       in_cl;
  } ppio_cfg_t;

  localparam ppio_cfg_t CFG_RESET = '{mode_a: 2'b00, in_a: 1'b1, in_cu: 1'b1,
                                      mode_b: 1'b0, in_b: 1'b1, in_cl: 1'b1};

  typedef enum logic [1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CTL = 2'd3
  } ppio_sel_e;
endpackage

// File: rtl/ppio_decode.sv
module ppio_decode
  import ppio_pkg::*;
(
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  output logic       wr_a,
  output logic       wr_b,
  output logic       wr_c,
  output logic       wr_ctl,
  output logic       rd_en,
  output ppio_sel_e  rd_sel
);
  logic wr_en;
  assign wr_en  = !cs_n && !wr_n;
  assign rd_en  = !cs_n && !rd_n;
  assign rd_sel = ppio_sel_e'(addr);
  assign wr_a   = wr_en && (addr == SEL_A);
  assign wr_b   = wr_en && (addr == SEL_B);
  assign wr_c   = wr_en && (addr == SEL_C);
  assign wr_ctl = wr_en && (addr == SEL_CTL);
endmodule

// File: rtl/ppio_cfg.sv
module ppio_cfg
  import ppio_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctl,
  input  logic [7:0]       wdata,
  output ppio_cfg_t        cfg,
  output logic             def_en,
  output logic             bit_en,
  output logic [IDX_W-1:0] bit_idx,
  output logic             bit_val
);
  assign def_en  = wr_ctl && wdata[7];
  assign bit_en  = wr_ctl && !wdata[7];
  assign bit_idx = wdata[IDX_W:1];
  assign bit_val = wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_RESET;
    end else if (def_en) begin
      cfg.mode_a <= wdata[6:5];
      cfg.in_a   <= wdata[4];
      cfg.in_cu  <= wdata[3];
      cfg.mode_b <= wdata[2];
      cfg.in_b   <= wdata[1];
      cfg.in_cl  <= wdata[0];
    end
  end

  // R5: a bit command never alters the stored configuration
  a_r5_bit_cmd_keeps_cfg: assert property (@(posedge clk) disable iff (rst)
    bit_en |=> $stable(cfg));
endmodule

// File: rtl/ppio_latch.sv
module ppio_latch #(
  parameter int W     = 8,
  parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ld,
  input  logic [W-1:0]     ld_mask,
  input  logic [W-1:0]     ld_data,
  input  logic             bit_en,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             bit_val,
  output logic [W-1:0]     q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr)
        q[i] <= 1'b0;
      else if (ld && ld_mask[i])
        q[i] <= ld_data[i];
      else if (bit_en && (bit_idx == IDX_W'(i)))
        q[i] <= bit_val;
    end
  end

  // R4: a bit command flips at most one latch bit
  a_r4_single_bit: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !ld && !clr) |=> ($countones(q ^ $past(q)) <= 1));
  // R7: masked-off bits hold through a load
  a_r7_masked_hold: assert property (@(posedge clk) disable iff (rst)
    (ld && !clr) |=> (((q ^ $past(q)) & ~$past(ld_mask)) == '0));
endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
  import ppio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  input  logic [DATA_W-1:0] pa_in,
  output logic [DATA_W-1:0] pa_out,
  output logic [DATA_W-1:0] pa_oe,
  input  logic [DATA_W-1:0] pb_in,
  output logic [DATA_W-1:0] pb_out,
  output logic [DATA_W-1:0] pb_oe,
  input  logic [DATA_W-1:0] pc_in,
  output logic [DATA_W-1:0] pc_out,
  output logic [DATA_W-1:0] pc_oe,
  output logic [1:0]        mode_a,
  output logic              mode_b
);
  localparam int NIB   = DATA_W / 2;
  localparam int IDX_W = $clog2(DATA_W);

  logic wr_a, wr_b, wr_c, wr_ctl, rd_en;
  ppio_sel_e rd_sel;
  ppio_cfg_t cfg;
  logic def_en, bit_en, bit_val;
  logic [IDX_W-1:0] bit_idx;
  logic [DATA_W-1:0] c_out_mask, c_in_mask;

  ppio_decode u_dec (
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wr_a(wr_a), .wr_b(wr_b), .wr_c(wr_c), .wr_ctl(wr_ctl),
    .rd_en(rd_en), .rd_sel(rd_sel)
  );

  ppio_cfg #(.IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_ctl(wr_ctl), .wdata(wdata[7:0]),
    .cfg(cfg), .def_en(def_en), .bit_en(bit_en),
    .bit_idx(bit_idx), .bit_val(bit_val)
  );

  assign c_in_mask  = {{NIB{cfg.in_cu}}, {NIB{cfg.in_cl}}};
  assign c_out_mask = ~c_in_mask;

  ppio_latch #(.W(DATA_W)) u_pa (
    .clk(clk), .rst(rst), .clr(def_en), .ld(wr_a), .ld_mask({DATA_W{1'b1}}),
    .ld_data(wdata), .bit_en(1'b0), .bit_idx('0), .bit_val(1'b0), .q(pa_out)
  );

  ppio_latch #(.W(DATA_W)) u_pb (
    .clk(clk), .rst(rst), .clr(def_en), .ld(wr_b), .ld_mask({DATA_W{1'b1}}),
    .ld_data(wdata), .bit_en(1'b0), .bit_idx('0), .bit_val(1'b0), .q(pb_out)
  );

  ppio_latch #(.W(DATA_W)) u_pc (
    .clk(clk), .rst(rst), .clr(def_en), .ld(wr_c), .ld_mask(c_out_mask),
    .ld_data(wdata), .bit_en(bit_en), .bit_idx(bit_idx), .bit_val(bit_val),
    .q(pc_out)
  );

  assign pa_oe  = {DATA_W{~cfg.in_a}};
  assign pb_oe  = {DATA_W{~cfg.in_b}};
  assign pc_oe  = c_out_mask;
  assign mode_a = cfg.mode_a;
  assign mode_b = cfg.mode_b;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (rd_sel)
        SEL_A:   rdata = cfg.in_a ? pa_in : pa_out;
        SEL_B:   rdata = cfg.in_b ? pb_in : pb_out;
        SEL_C:   rdata = (pc_in & c_in_mask) | (pc_out & c_out_mask);
        default: rdata = '0;
      endcase
    end
  end
  assign rdata_oe = rd_en;

  // R1: on leaving reset every pad is released
  a_r1_released: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0 && pc_out == '0));
  // R9: control address reads back zero
  a_r9_ctl_read_zero: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n && addr == 2'd3) |-> (rdata == '0));
  // R10: no write lands while the chip is deselected
  a_r10_deselect_hold: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) && $stable(mode_a)));
  // R3: a direction word empties every latch
  a_r3_def_clears: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !wr_n && addr == 2'd3 && wdata[7]) |=> (pa_out == '0 && pb_out == '0 && pc_out == '0));
endmodule

// File: tb/sim_ppio_ctrl.sv
`timescale 1ns/1ps
module sim_ppio_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
  logic rdata_oe, mode_b;
  logic [1:0] mode_a;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ppio_ctrl u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
    .mode_a(mode_a), .mode_b(mode_b)
  );

  // table: direction word, expected A/B/C enables, modes
  localparam int NV = 8;
  localparam logic [7:0] T_CW  [NV] = '{8'h80, 8'h9B, 8'h88, 8'h81, 8'h90, 8'h82, 8'hC4, 8'hA5};
  localparam logic [7:0] T_AOE [NV] = '{8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF};
  localparam logic [7:0] T_BOE [NV] = '{8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hFF, 8'hFF};
  localparam logic [7:0] T_COE [NV] = '{8'hFF, 8'h00, 8'h0F, 8'hF0, 8'hFF, 8'hFF, 8'hFF, 8'hF0};
  localparam logic [1:0] T_MA  [NV] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd2, 2'd1};
  localparam logic       T_MB  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic sel_n = 1'b0);
    @(negedge clk);
    cs_n = sel_n; wr_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 oe", {pa_oe, pb_oe, pc_oe}, 24'h0);
    chk("R1 latch", {pa_out, pb_out, pc_out}, 24'h0);
    chk("R1 mode", {mode_a, mode_b}, 3'b000);
    chk("R10 idle bus", {rdata, rdata_oe}, 9'h0);

    // table walk: R2, R3, R11, R7, R8
    pc_in = 8'h3C;
    for (int i = 0; i < NV; i++) begin
      bus_wr(2'd3, T_CW[i]);
      chk("R2 enables", {pa_oe, pb_oe, pc_oe}, {T_AOE[i], T_BOE[i], T_COE[i]});
      chk("R11 modes", {mode_a, mode_b}, {T_MA[i], T_MB[i]});
      chk("R3 cleared", pc_out, 8'h00);
      bus_wr(2'd2, 8'hFF);
      chk("R7 nibble mask", pc_out, T_COE[i]);
      bus_rd(2'd2, rv);
      chk("R8 port C read", rv, T_COE[i] | (~T_COE[i] & 8'h3C));
    end

    // R6 A/B output
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd0, 8'h5A);
    bus_wr(2'd1, 8'hC3);
    chk("R6 port A latch", pa_out, 8'h5A);
    chk("R6 port B latch", pb_out, 8'hC3);
    pa_in = 8'h11;
    bus_rd(2'd0, rv);
    chk("R8 output read A", rv, 8'h5A);

    // R4 / R5 bit commands
    bus_wr(2'd3, 8'h0B);            // set bit 5
    chk("R4 set bit5", pc_out, 8'h20);
    bus_wr(2'd3, 8'h75);            // junk in 6..4, set bit 2
    chk("R4 junk ignored", pc_out, 8'h24);
    bus_wr(2'd3, 8'h0A);            // clear bit 5
    chk("R4 clear bit5", pc_out, 8'h04);
    chk("R5 cfg kept", {pa_oe, pb_oe, pc_oe, 3'(mode_a), 1'(mode_b)}, {24'hFFFFFF, 4'h0});
    chk("R5 A latch kept", pa_out, 8'h5A);

    // R3 direction word clears A/B
    bus_wr(2'd3, 8'h80);
    chk("R3 A/B cleared", {pa_out, pb_out}, 16'h0);

    // R8 input read
    bus_wr(2'd3, 8'h92);
    pa_in = 8'hA5; pb_in = 8'h3E;
    bus_rd(2'd0, rv);
    chk("R8 input A", rv, 8'hA5);
    bus_rd(2'd1, rv);
    chk("R8 input B", rv, 8'h3E);

    // R9 control read
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd0, 8'h66);
    bus_rd(2'd3, rv);
    chk("R9 ctl read", rv, 8'h00);
    chk("R9 no change", {pa_out, pa_oe}, 16'h66FF);

    // R10 deselected write and read
    bus_wr(2'd0, 8'h99, 1'b1);
    chk("R10 deselect write", pa_out, 8'h66);
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b0; addr = 2'd0;
    #1 chk("R10 deselect read", {rdata, rdata_oe}, 9'h0);
    @(negedge clk);
    rd_n = 1'b1;

    // R1 reset after configuration
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 late reset", {pa_oe, pb_oe, pc_oe, pa_out}, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule